// File: doc/BRIEF.md
# I2C-Style Serial Byte Engine

This block is the bit-level core of a byte-oriented two-wire serial port. It watches already synchronized and glitch-filtered samples of the clock line (SCL) and the data line (SDA). It counts the clock pulses of each byte and gathers the eight data bits, most significant first. On the ninth pulse it samples the acknowledge level. It moves the gathered byte into a 9-bit receive buffer, and it raises single-cycle event strobes that an interrupt controller can take as its sources.

Two configuration bits shape the timing. The clock-delay option turns the buffer load into two steps, one at each edge of the ninth pulse, and the first step uses a shifted bit layout. The alternate-event option replaces the acknowledge/not-acknowledge strobes with plain transmit/receive strobes. A third strobe reports either START or STOP detection, as configured.

On the output side the engine drives SDA open-drain, through a single pull-low enable. Each new data level is applied a fixed number of clocks after the SCL falling edge is seen. While the engine is disabled, SDA follows a preset level.

Top module: `i2c_byte_engine`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `rx_buf` is 0, every event strobe is 0 and `sda_pull` is 0 (SDA released).
- R2: With `cfg_alt_irq`=0, the rising SCL edge of the ninth pulse raises `ev_ack` if `sda_i` is 0, or `ev_nack` if it is 1. The strobe lasts one cycle, and the two are never high together.
- R3: The rising edge of the ninth pulse loads the eight received bits into `rx_buf[7:0]`, with the first bit in bit 7. `rx_buf[8]` is left unchanged.
- R4: With `cfg_clk_delay`=1, the falling SCL edge that starts the ninth bit period loads received bits 1 to 7 into `rx_buf[6:0]` (bit 1 in bit 6) and bit 8 into `rx_buf[8]`, and leaves `rx_buf[7]` unchanged.
- R5: With `cfg_clk_delay`=1, the rising edge of the ninth pulse performs a second load, as in R3, so that `rx_buf[7:0]` then holds the whole byte.
- R6: With `cfg_alt_irq`=1 and `cfg_clk_delay`=0, `ev_tx` pulses on the rising edge of the ninth pulse and `ev_rx` on the falling edge that starts the ninth bit period. `ev_ack` and `ev_nack` stay low.
- R7: With `cfg_alt_irq`=1 and `cfg_clk_delay`=1, `ev_rx` pulses as in R6. `ev_tx` pulses once, on the falling edge that ends the ninth pulse, when `cfg_tx_both`=0. When `cfg_tx_both`=1 it pulses twice, on the falling edge that starts the ninth bit period and on the ninth rising edge.
- R8: `ev_stsp` pulses for one cycle on START (SDA falling while SCL stays high) when `cfg_stsp_sel`=0, and on STOP (SDA rising while SCL stays high) when `cfg_stsp_sel`=1.
- R9: A START in the middle of a byte discards the bits gathered so far. The next byte is then received whole.
- R10: With `cfg_tx_mode`=1, each SCL falling edge before a data bit puts that bit of the last byte loaded by `tx_load` on SDA, most significant bit first (`sda_pull`=1 for a 0). The new level appears HOLD_CYC clocks after the edge that sees the fall. SDA is released for the ninth bit.
- R11: With `cfg_tx_mode`=0, SDA is released for the eight data bits. During the ninth bit period `sda_pull` equals `ack_drive`.
- R12: While `en` is 0, `sda_pull` equals the inverse of `cfg_sda_init`, no event strobe fires and the bit count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Engine enable |
| scl_i | input | 1 | Filtered SCL sample |
| sda_i | input | 1 | Filtered SDA sample |
| cfg_clk_delay | input | 1 | Two-step buffer load and delayed transmit event |
| cfg_alt_irq | input | 1 | 1: transmit/receive strobes, 0: ACK/NACK strobes |
| cfg_tx_both | input | 1 | With delay: transmit strobe on both ninth-pulse edges |
| cfg_stsp_sel | input | 1 | 0: report START, 1: report STOP |
| cfg_sda_init | input | 1 | SDA level while disabled and after enabling |
| cfg_tx_mode | input | 1 | 1: engine sends data bits |
| ack_drive | input | 1 | Pull SDA low during the ninth bit when receiving |
| tx_byte | input | 8 | Byte to send |
| tx_load | input | 1 | Capture `tx_byte` |
| rx_buf | output | 9 | Receive buffer |
| ev_ack | output | 1 | Acknowledge seen |
| ev_nack | output | 1 | Not-acknowledge seen |
| ev_tx | output | 1 | Transmit event |
| ev_rx | output | 1 | Receive event |
| ev_stsp | output | 1 | START or STOP event |
| sda_pull | output | 1 | Open-drain pull-low enable for SDA |

## Verification
The engine registers the line samples once. Every event strobe and every `rx_buf` load is therefore visible in the cycle that follows the first clock edge at which the changed SCL or SDA level is present. The SDA level lags that edge by HOLD_CYC further clocks. The bench changes one line at a time on a falling clock edge and then holds it for six clocks, which is longer than both latencies. A behavioural model advances on each rising edge and is compared with every output on each falling edge. Directed checks read the buffer and the SDA drive after each step has settled, and they count the event strobes per transaction.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  localparam int BYTE_W = 8;
  localparam int BUF_W  = BYTE_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  // count value while the ninth pulse is pending / after its rising edge
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_POST = CNT_W'(BYTE_W + 1);

  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } line_ev_t;

  // full load: whole byte into the low bits, top bit kept
  function automatic logic [BUF_W-1:0] f_load_full(input logic [BYTE_W-1:0] sh,
                                                   input logic [BUF_W-1:0]  cur);
    return {cur[BUF_W-1], sh};
  endfunction

  // early load: bits 1..7 into low bits, last bit on top, bit 7 kept
  function automatic logic [BUF_W-1:0] f_load_early(input logic [BYTE_W-1:0] sh,
                                                    input logic [BUF_W-1:0]  cur);
    return {sh[0], cur[BYTE_W-1], sh[BYTE_W-1:1]};
  endfunction

  // SDA level for the bit period that begins with a falling SCL edge
  function automatic logic f_next_level(input logic              tx_mode,
                                        input logic [BYTE_W-1:0] txd,
                                        input logic [CNT_W-1:0]  cnt,
                                        input logic              ack_drive);
    logic [BYTE_W-1:0] sh;
    if (cnt == CNT_ACK) return tx_mode ? 1'b1 : ~ack_drive;
    if (!tx_mode) return 1'b1;
    if (cnt == CNT_POST) return txd[BYTE_W-1];
    sh = txd << cnt;
    return sh[BYTE_W-1];
  endfunction

  // transmit strobe selection
  function automatic logic f_tx_fire(input logic delay, input logic both,
                                     input logic r9, input logic f9, input logic fp9);
    if (!delay) return r9;
    if (both) return r9 | f9;
    return fp9;
  endfunction

endpackage

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
  import i2c_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl_i,
  input  logic              sda_i,
  output line_ev_t          line_ev,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [BYTE_W-1:0] shreg,
  output logic              rise9,
  output logic              fall9,
  output logic              fall_post9
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    line_ev.rise  = scl_i & ~scl_q;
    line_ev.fall  = ~scl_i & scl_q;
    line_ev.start = scl_i & scl_q & sda_q & ~sda_i;
    line_ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
  end

  assign rise9      = en & line_ev.rise & (bit_cnt == CNT_ACK);
  assign fall9      = en & line_ev.fall & (bit_cnt == CNT_ACK);
  assign fall_post9 = en & line_ev.fall & (bit_cnt == CNT_POST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (!en || line_ev.start) begin
      bit_cnt <= '0;
    end else if (line_ev.rise && (bit_cnt < CNT_ACK)) begin
      shreg   <= {shreg[BYTE_W-2:0], sda_i};
      bit_cnt <= bit_cnt + CNT_W'(1);
    end else if (rise9) begin
      bit_cnt <= CNT_POST;
    end else if (fall_post9) begin
      bit_cnt <= '0;
    end
  end

endmodule

// File: rtl/i2c_rx_stage.sv
module i2c_rx_stage
  import i2c_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clk_delay,
  input  logic [BYTE_W-1:0] shreg,
  input  logic              rise9,
  input  logic              fall9,
  output logic [BUF_W-1:0]  rx_buf
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_buf <= '0;
    end else if (rise9) begin
      rx_buf <= f_load_full(shreg, rx_buf);
    end else if (fall9 && cfg_clk_delay) begin
      rx_buf <= f_load_early(shreg, rx_buf);
    end
  end

endmodule

// File: rtl/i2c_evt_route.sv
module i2c_evt_route
  import i2c_eng_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     sda_i,
  input  line_ev_t line_ev,
  input  logic     rise9,
  input  logic     fall9,
  input  logic     fall_post9,
  input  logic     cfg_alt_irq,
  input  logic     cfg_clk_delay,
  input  logic     cfg_tx_both,
  input  logic     cfg_stsp_sel,
  output logic     ev_ack,
  output logic     ev_nack,
  output logic     ev_tx,
  output logic     ev_rx,
  output logic     ev_stsp
);

  logic tx_hit;
  assign tx_hit = f_tx_fire(cfg_clk_delay, cfg_tx_both, rise9, fall9, fall_post9);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_ack  <= 1'b0;
      ev_nack <= 1'b0;
      ev_tx   <= 1'b0;
      ev_rx   <= 1'b0;
      ev_stsp <= 1'b0;
    end else begin
      ev_ack  <= rise9 & ~cfg_alt_irq & ~sda_i;
      ev_nack <= rise9 & ~cfg_alt_irq & sda_i;
      ev_tx   <= cfg_alt_irq & tx_hit;
      ev_rx   <= cfg_alt_irq & fall9;
      ev_stsp <= en & (cfg_stsp_sel ? line_ev.stop : line_ev.start);
    end
  end

endmodule

// File: rtl/i2c_sda_drive.sv
module i2c_sda_drive
  import i2c_eng_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl_fall,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              cfg_sda_init,
  input  logic              cfg_tx_mode,
  input  logic              ack_drive,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_load,
  output logic              sda_pull
);

  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [BYTE_W-1:0] txreg;
  logic [HW-1:0]     hold_q;
  logic              pend_q, lvl_q, nxt;

  assign nxt = f_next_level(cfg_tx_mode, txreg, bit_cnt, ack_drive);

  always_ff @(posedge clk) begin
    if (!rst_n) txreg <= '0;
    else if (tx_load) txreg <= tx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= 1'b1;
      lvl_q  <= 1'b1;
    end else if (!en) begin
      hold_q <= '0;
      lvl_q  <= cfg_sda_init;
    end else if (scl_fall) begin
      pend_q <= nxt;
      hold_q <= HW'(HOLD_CYC);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - HW'(1);
      if (hold_q == HW'(1)) lvl_q <= pend_q;
    end
  end

  assign sda_pull = ~lvl_q;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              cfg_clk_delay,
  input  logic              cfg_alt_irq,
  input  logic              cfg_tx_both,
  input  logic              cfg_stsp_sel,
  input  logic              cfg_sda_init,
  input  logic              cfg_tx_mode,
  input  logic              ack_drive,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_load,
  output logic [BUF_W-1:0]  rx_buf,
  output logic              ev_ack,
  output logic              ev_nack,
  output logic              ev_tx,
  output logic              ev_rx,
  output logic              ev_stsp,
  output logic              sda_pull
);

  // named internal events, also observed by the checker
  line_ev_t          line_ev;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              rise9, fall9, fall_post9;
  logic              start_seen;

  assign start_seen = en & line_ev.start;

  i2c_bit_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .scl_i(scl_i), .sda_i(sda_i),
    .line_ev(line_ev), .bit_cnt(bit_cnt), .shreg(shreg),
    .rise9(rise9), .fall9(fall9), .fall_post9(fall_post9)
  );

  i2c_rx_stage u_rx (
    .clk(clk), .rst_n(rst_n), .cfg_clk_delay(cfg_clk_delay),
    .shreg(shreg), .rise9(rise9), .fall9(fall9), .rx_buf(rx_buf)
  );

  i2c_evt_route u_evt (
    .clk(clk), .rst_n(rst_n), .en(en), .sda_i(sda_i), .line_ev(line_ev),
    .rise9(rise9), .fall9(fall9), .fall_post9(fall_post9),
    .cfg_alt_irq(cfg_alt_irq), .cfg_clk_delay(cfg_clk_delay),
    .cfg_tx_both(cfg_tx_both), .cfg_stsp_sel(cfg_stsp_sel),
    .ev_ack(ev_ack), .ev_nack(ev_nack), .ev_tx(ev_tx), .ev_rx(ev_rx),
    .ev_stsp(ev_stsp)
  );

  i2c_sda_drive #(.HOLD_CYC(HOLD_CYC)) u_sda (
    .clk(clk), .rst_n(rst_n), .en(en), .scl_fall(line_ev.fall),
    .bit_cnt(bit_cnt), .cfg_sda_init(cfg_sda_init), .cfg_tx_mode(cfg_tx_mode),
    .ack_drive(ack_drive), .tx_byte(tx_byte), .tx_load(tx_load),
    .sda_pull(sda_pull)
  );

endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk
  import i2c_eng_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              cfg_alt_irq,
  input logic              cfg_clk_delay,
  input logic [BUF_W-1:0]  rx_buf,
  input logic              ev_ack,
  input logic              ev_nack,
  input logic              ev_tx,
  input logic              ev_rx,
  input logic              ev_stsp,
  input logic              start_seen,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [BYTE_W-1:0] shreg,
  input logic              rise9,
  input logic              fall9
);

  assert_ack_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_ack && ev_nack));

  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack || ev_nack) |=> !(ev_ack || ev_nack));

  assert_ack_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack || ev_nack) |-> !$past(cfg_alt_irq));

  assert_txrx_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx || ev_rx) |-> $past(cfg_alt_irq));

  assert_full_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise9 |=> (rx_buf[BYTE_W-1:0] == $past(shreg)));

  assert_early_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall9 && cfg_clk_delay) |=>
      (rx_buf[BUF_W-1] == $past(shreg[0])) &&
      (rx_buf[BYTE_W-2:0] == $past(shreg[BYTE_W-1:1])));

  assert_start_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (bit_cnt == '0));

  assert_quiet_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(ev_ack || ev_nack || ev_tx || ev_rx || ev_stsp));

endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cfg_alt_irq(cfg_alt_irq),
  .cfg_clk_delay(cfg_clk_delay), .rx_buf(rx_buf),
  .ev_ack(ev_ack), .ev_nack(ev_nack), .ev_tx(ev_tx), .ev_rx(ev_rx),
  .ev_stsp(ev_stsp), .start_seen(start_seen), .bit_cnt(bit_cnt),
  .shreg(shreg), .rise9(rise9), .fall9(fall9)
);

// File: tb/i2c_byte_engine_bench.sv
`timescale 1ns/1ps
module i2c_byte_engine_bench;

  localparam int HOLD = 2;
  localparam int WD   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, scl = 1'b1, sda = 1'b1;
  logic c_delay = 1'b0, c_alt = 1'b0, c_both = 1'b0, c_stsp = 1'b0;
  logic c_init = 1'b1, c_txm = 1'b0, ackd = 1'b0;
  logic [7:0] txb = 8'h00;
  logic txl = 1'b0;
  logic [8:0] rx_buf;
  logic ev_ack, ev_nack, ev_tx, ev_rx, ev_stsp, sda_pull;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int c_ack = 0, c_nack = 0, c_tx = 0, c_rx = 0, c_st = 0;

  always #10 clk = ~clk;

  i2c_byte_engine #(.HOLD_CYC(HOLD)) u_i2c_byte_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .scl_i(scl), .sda_i(sda),
    .cfg_clk_delay(c_delay), .cfg_alt_irq(c_alt), .cfg_tx_both(c_both),
    .cfg_stsp_sel(c_stsp), .cfg_sda_init(c_init), .cfg_tx_mode(c_txm),
    .ack_drive(ackd), .tx_byte(txb), .tx_load(txl), .rx_buf(rx_buf),
    .ev_ack(ev_ack), .ev_nack(ev_nack), .ev_tx(ev_tx), .ev_rx(ev_rx),
    .ev_stsp(ev_stsp), .sda_pull(sda_pull)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int got[$];
  bit nine;
  int hold;
  logic lvl, pend, p_scl, p_sda;
  logic [7:0] txv;
  logic [8:0] m_buf;
  logic m_ack, m_nack, m_tx, m_rx, m_st;

  always @(posedge clk) begin
    if (!rst_n) begin
      got.delete(); nine = 0; hold = 0; lvl = 1; pend = 1;
      p_scl = 1; p_sda = 1; txv = 0; m_buf = 0;
      m_ack = 0; m_nack = 0; m_tx = 0; m_rx = 0; m_st = 0;
    end else begin
      bit rise, fall, strt, stp;
      int nb;
      m_ack = 0; m_nack = 0; m_tx = 0; m_rx = 0; m_st = 0;
      rise = scl && !p_scl;
      fall = !scl && p_scl;
      strt = p_scl && scl && p_sda && !sda;
      stp  = p_scl && scl && !p_sda && sda;
      nb = nine ? 9 : got.size();
      if (!en) begin
        got.delete(); nine = 0; hold = 0; lvl = c_init;
      end else begin
        if ((strt && !c_stsp) || (stp && c_stsp)) m_st = 1;
        if (fall) begin
          if (nb == 8) pend = c_txm ? 1'b1 : !ackd;
          else if (!c_txm) pend = 1'b1;
          else if (nb == 9) pend = txv[7];
          else pend = txv[7-nb];
          hold = HOLD;
        end else if (hold > 0) begin
          if (hold == 1) lvl = pend;
          hold--;
        end
        if (strt) begin
          got.delete(); nine = 0;
        end else if (rise) begin
          if (got.size() < 8) got.push_back(int'(sda));
          else if (!nine) begin
            nine = 1;
            for (int i = 0; i < 8; i++) m_buf[7-i] = got[i][0];
            if (!c_alt) begin m_ack = !sda; m_nack = sda; end
            else if (!c_delay || c_both) m_tx = 1;
          end
        end else if (fall) begin
          if (nine) begin
            got.delete(); nine = 0;
            if (c_alt && c_delay && !c_both) m_tx = 1;
          end else if (got.size() == 8) begin
            if (c_delay) begin
              for (int i = 0; i < 7; i++) m_buf[6-i] = got[i][0];
              m_buf[8] = got[7][0];
            end
            if (c_alt) begin
              m_rx = 1;
              if (c_delay && c_both) m_tx = 1;
            end
          end
        end
      end
      if (txl) txv = txb;
      p_scl = scl; p_sda = sda;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R3,R4,R5 model rx_buf", {7'd0, rx_buf}, {7'd0, m_buf});
      chk("R2 model ack/nack", {14'd0, ev_ack, ev_nack}, {14'd0, m_ack, m_nack});
      chk("R6,R7 model tx/rx", {14'd0, ev_tx, ev_rx}, {14'd0, m_tx, m_rx});
      chk("R8 model stsp", {15'd0, ev_stsp}, {15'd0, m_st});
      chk("R10,R11,R12 model sda_pull", {15'd0, sda_pull}, {15'd0, !lvl});
      if (rst_n) begin
        c_ack += int'(ev_ack); c_nack += int'(ev_nack);
        c_tx += int'(ev_tx); c_rx += int'(ev_rx); c_st += int'(ev_stsp);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input logic v_scl, input logic v_sda);
    @(negedge clk);
    scl = v_scl; sda = v_sda;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_start();
    if (scl == 1'b0) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic do_stop();
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
  endtask

  task automatic clk_bit(input logic b);
    step(1'b0, b);
    step(1'b1, b);
    step(1'b0, b);
  endtask

  task automatic send8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
  endtask

  initial begin
    int s_ack, s_nack, s_tx, s_rx, s_st;
    repeat (3) @(negedge clk);
    chk("R1 reset rx_buf", {7'd0, rx_buf}, 16'h0000);
    chk("R1 reset events", {11'd0, ev_ack, ev_nack, ev_tx, ev_rx, ev_stsp}, 16'h0000);
    chk("R1 reset sda_pull", {15'd0, sda_pull}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release rx_buf", {7'd0, rx_buf}, 16'h0000);

    // R12: disabled engine follows preset, no events
    c_init = 1'b0; repeat (3) @(negedge clk);
    chk("R12 preset low pulls", {15'd0, sda_pull}, 16'h0001);
    s_st = c_st; s_ack = c_ack;
    do_start(); send8(8'hFF); clk_bit(1'b0); do_stop();
    chk("R12 no events while off", 16'(c_st - s_st + c_ack - s_ack), 16'h0000);
    c_init = 1'b1; repeat (3) @(negedge clk);
    chk("R12 preset high releases", {15'd0, sda_pull}, 16'h0000);

    // R2 R3 R11 receive, no delay, ACK/NACK strobes
    en = 1'b1; ackd = 1'b1;
    s_ack = c_ack; s_nack = c_nack; s_st = c_st;
    do_start();
    send8(8'hA5);
    chk("R11 ninth bit drives ack", {15'd0, sda_pull}, 16'h0001);
    clk_bit(1'b0);
    chk("R11 released after ninth", {15'd0, sda_pull}, 16'h0000);
    chk("R3 byte A5", {7'd0, rx_buf}, 16'h00A5);
    send8(8'h3C); clk_bit(1'b1);
    chk("R3 byte 3C", {7'd0, rx_buf}, 16'h003C);
    do_stop();
    chk("R2 ack count", 16'(c_ack - s_ack), 16'h0001);
    chk("R2 nack count", 16'(c_nack - s_nack), 16'h0001);
    chk("R8 start count", 16'(c_st - s_st), 16'h0001);

    // R4 R5 two-step load
    c_delay = 1'b1; ackd = 1'b0;
    do_start();
    send8(8'hB3);
    chk("R4 early layout", {7'd0, rx_buf}, 16'h0159);
    chk("R11 no ack drive", {15'd0, sda_pull}, 16'h0000);
    clk_bit(1'b0);
    chk("R5 second load", {7'd0, rx_buf}, 16'h01B3);
    do_stop();

    // R6 alternate strobes, no delay
    c_delay = 1'b0; c_alt = 1'b1;
    s_ack = c_ack; s_nack = c_nack; s_tx = c_tx; s_rx = c_rx;
    do_start(); send8(8'h0F); clk_bit(1'b1); do_stop();
    chk("R6 tx count", 16'(c_tx - s_tx), 16'h0001);
    chk("R6 rx count", 16'(c_rx - s_rx), 16'h0001);
    chk("R6 ack/nack silent", 16'(c_ack - s_ack + c_nack - s_nack), 16'h0000);

    // R7 alternate strobes with delay
    c_delay = 1'b1; c_both = 1'b0;
    s_tx = c_tx; s_rx = c_rx;
    do_start(); send8(8'h81); clk_bit(1'b0);
    chk("R7 tx after ninth", 16'(c_tx - s_tx), 16'h0001);
    chk("R7 rx once", 16'(c_rx - s_rx), 16'h0001);
    c_both = 1'b1; s_tx = c_tx;
    send8(8'h42); clk_bit(1'b0); do_stop();
    chk("R7 tx both edges", 16'(c_tx - s_tx), 16'h0002);
    c_both = 1'b0; c_delay = 1'b0; c_alt = 1'b0;

    // R8 stop selection
    c_stsp = 1'b1; s_st = c_st;
    do_start(); do_stop();
    chk("R8 stop only", 16'(c_st - s_st), 16'h0001);
    c_stsp = 1'b0;

    // R9 restart mid-byte
    do_start();
    clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b1);
    do_start();
    send8(8'h96); clk_bit(1'b0);
    chk("R9 byte after restart", {7'd0, rx_buf}, 16'h0096);
    do_stop();

    // R10 transmit MSB first, released on ninth bit
    c_txm = 1'b1; s_ack = c_ack;
    @(negedge clk); txb = 8'hC6; txl = 1'b1;
    @(negedge clk); txl = 1'b0;
    do_start();
    for (int i = 7; i >= 0; i--) begin
      chk("R10 tx bit level", {15'd0, sda_pull}, {15'd0, ~txb[i]});
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
    end
    chk("R10 released for ninth", {15'd0, sda_pull}, 16'h0000);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk("R10 next byte first bit", {15'd0, sda_pull}, 16'h0000);
    chk("R2 ack seen while sending", 16'(c_ack - s_ack), 16'h0001);
    do_stop();
    c_txm = 1'b0;

    // R12 disable mid-byte
    do_start(); clk_bit(1'b1); clk_bit(1'b0);
    c_init = 1'b0; en = 1'b0; repeat (3) @(negedge clk);
    chk("R12 disable applies preset", {15'd0, sda_pull}, 16'h0001);
    s_st = c_st; s_rx = c_rx;
    do_stop();
    chk("R12 silent while off", 16'(c_st - s_st + c_rx - s_rx), 16'h0000);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired, run incomplete for R1 onward");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule